// File: doc/BRIEF.md
# Programmable qualified event counter

This block is one counter slice of a performance-monitoring unit. Every cycle it receives a small vector of one-bit sub-event strobes from several event sources and the current privilege level, 0 to 3. A configuration word picks one source and a mask of its sub-events. The selected strobes are summed into a per-cycle event count from 0 to 7. A threshold, an invert bit, an edge detector and a privilege filter then decide how much a 40-bit counter advances in that cycle.

Software programs the configuration, loads or reads the counter and clears a sticky overflow flag through a simple register port. The write port is synchronous and the read port is combinational. When the counter wraps past all-ones the flag is set, and the interrupt output follows the flag when the interrupt enable bit is set. Some event codes are legal on only one counter index, given by a parameter. On any other index such an event counts nothing.

The qualifier holds a three-state machine:
- `Q_OFF`: the counter is disabled.
- `Q_LOW`: the qualified condition was false in the previous cycle, or the configuration has just been written.
- `Q_HIGH`: the condition was true in the previous cycle.

The transitions are:
- `LOAD_ON`: a configuration write with the enable bit set leads to `Q_LOW`.
- `LOAD_OFF`: a configuration write with the enable bit clear leads to `Q_OFF`.
- `RISE`: from `Q_LOW` to `Q_HIGH` when the condition is true.
- `FALL`: from `Q_HIGH` to `Q_LOW` when the condition is false.
- `HOLD`: every other case keeps the state.

In edge mode a count is made only on `RISE`.

Top module: `qual_event_counter`

## Requirements
- R1: After reset, the counter reads 0, the configuration reads 0, the status reads 0 and `irq_o` is low.
- R2: With threshold field [26:24] equal to 0, the counter adds the per-cycle event count in each enabled cycle. The per-cycle count is the number of set bits in (selected source bits AND mask), capped at 7. The invert bit has no effect in this case.
- R3: With a nonzero threshold and the invert bit [21] clear, the counter adds 1 in each cycle where the per-cycle count is greater than or equal to the threshold, and 0 otherwise.
- R4: With a nonzero threshold and the invert bit set, the counter adds 1 in each cycle where the per-cycle count is below the threshold.
- R5: With edge bit [18] set, the counter adds 1 once per false-to-true change of the qualified condition. For threshold 0 the condition is a count above zero. A configuration write resets the remembered condition to false, so a condition that is true in the first cycle after the write counts once.
- R6: The user enable [16] admits privilege levels 1, 2 and 3. The OS enable [17] admits level 0. A cycle at a level that is not admitted counts nothing. When both bits are clear, all levels are admitted.
- R7: Event code bits [3:0] pick source s, which uses input bits [s*8+7:s*8]. A code whose low nibble is 4 or above selects nothing. Mask bit i (configuration bit 8+i) admits sub-event i.
- R8: Event codes 0x10 to 0x1F are restricted: an even code is legal only on counter index 0 and an odd code only on index 1. A restricted code on the wrong index counts nothing, even with the invert bit set.
- R9: With enable bit [20] clear, the counter never changes except through software writes.
- R10: The counter wraps modulo 2^40. On a wrap, status bit 0 becomes 1 and stays 1 until a status write with data bit 0 set. A status write with data bit 0 clear leaves it unchanged. `irq_o` is status bit 0 AND interrupt enable bit [19].
- R11: A counter write in the same cycle as an increment loads the written value, and that cycle's increment is lost.
- R12: Address 0 holds the configuration (bits [31:0]), address 1 the counter and address 2 the status. A configuration read returns the last written word, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_evt_i | input | NSRC*NSUB (32) | Sub-event strobes, NSUB bits per source |
| priv_i | input | 2 | Current privilege level |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | CTR_W (40) | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | CTR_W (40) | Register read data, combinational |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A wrong qualifier state shows up as a counter value that is off by whole units after a single burst. In particular, a stale `Q_HIGH` after a configuration write loses the first edge, and that loss is visible on the very next counter read. A wrong per-cycle sum or threshold decision multiplies its error by the number of cycles in the burst, so a three-cycle burst separates all 128 combinations of threshold, invert and count. A lost or stuck overflow flag appears on the status read and on `irq_o` in the cycle after the wrapping increment.

// File: rtl/qec_pkg.sv
package qec_pkg;
    localparam int CFG_W = 32;
    localparam int SUM_W = 3;

    localparam logic [1:0] A_CFG  = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    typedef struct packed {
        logic [4:0] rsv_hi;
        logic [2:0] thr;
        logic [1:0] rsv_lo;
        logic       inv;
        logic       en;
        logic       int_en;
        logic       edge_en;
        logic       os_en;
        logic       usr_en;
        logic [7:0] umask;
        logic [7:0] code;
    } cfg_t;

    typedef enum logic [1:0] {
        Q_OFF  = 2'd0,
        Q_LOW  = 2'd1,
        Q_HIGH = 2'd2
    } qstate_t;
endpackage

// File: rtl/qec_event_sel.sv
module qec_event_sel
    import qec_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int NSUB   = 8,
    parameter int CTR_ID = 0
) (
    input  logic [NSRC*NSUB-1:0] sub_evt_i,
    input  logic [7:0]           code_i,
    input  logic [7:0]           umask_i,
    output logic [SUM_W-1:0]     sum_o,
    output logic                 legal_o
);
    localparam int  MAXSUM = (1 << SUM_W) - 1;
    localparam logic ID_LSB = 1'(CTR_ID % 2);
    localparam logic ID_OK  = (CTR_ID >= 0) && (CTR_ID < 2);

    logic [NSUB-1:0] picked;
    logic            restricted;
    int              acc;

    always_comb begin
        picked = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (4'(s) == code_i[3:0]) begin
                picked = sub_evt_i[s*NSUB +: NSUB];
            end
        end
    end

    always_comb begin
        acc = 0;
        for (int i = 0; i < NSUB; i++) begin
            acc = acc + int'(picked[i] & umask_i[i]);
        end
    end

    assign restricted = (code_i[7:4] == 4'h1);
    assign legal_o    = !restricted || (ID_OK && (code_i[0] == ID_LSB));
    assign sum_o      = !legal_o ? '0 :
                        (acc > MAXSUM) ? SUM_W'(MAXSUM) : SUM_W'(acc);
endmodule

// File: rtl/qec_qualifier.sv
module qec_qualifier
    import qec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] sum_i,
    input  logic             legal_i,
    input  logic [1:0]       priv_i,
    input  logic [2:0]       thr_i,
    input  logic             inv_i,
    input  logic             edge_i,
    input  logic             usr_i,
    input  logic             os_i,
    input  logic             en_i,
    input  logic             cfg_wr_i,
    input  logic             cfg_new_en_i,
    output logic [SUM_W-1:0] inc_o
);
    qstate_t state_q, state_d;
    logic    any_ring, priv_ok, raw_cond, cond;

    assign any_ring = !usr_i && !os_i;
    assign priv_ok  = (priv_i == 2'd0) ? (os_i || any_ring) : (usr_i || any_ring);
    assign raw_cond = (thr_i != 3'd0) ? ((sum_i >= thr_i) ^ inv_i) : (sum_i != '0);
    assign cond     = legal_i && priv_ok && raw_cond;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_OFF:   state_d = Q_OFF;
            Q_LOW:   state_d = cond ? Q_HIGH : Q_LOW;
            Q_HIGH:  state_d = cond ? Q_HIGH : Q_LOW;
            default: state_d = Q_OFF;
        endcase
        if (cfg_wr_i) state_d = cfg_new_en_i ? Q_LOW : Q_OFF;
    end

    always_comb begin
        inc_o = '0;
        unique case (state_q)
            Q_OFF: inc_o = '0;
            Q_LOW, Q_HIGH: begin
                if (edge_i)
                    inc_o = (state_q == Q_LOW && cond) ? SUM_W'(1) : '0;
                else if (thr_i != 3'd0)
                    inc_o = cond ? SUM_W'(1) : '0;
                else
                    inc_o = (legal_i && priv_ok) ? sum_i : '0;
            end
            default: inc_o = '0;
        endcase
    end

    // R5
    edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && inc_o != '0 && !cfg_wr_i) |=> (inc_o == '0));

    // R9
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (inc_o == '0));

    // R3
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_i != 3'd0) |-> (inc_o <= SUM_W'(1)));
endmodule

// File: rtl/qec_counter.sv
module qec_counter
    import qec_pkg::*;
#(
    parameter int CTR_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] inc_i,
    input  logic             cnt_wr_i,
    input  logic [CTR_W-1:0] cnt_wdata_i,
    input  logic             clr_ovf_i,
    output logic [CTR_W-1:0] cnt_o,
    output logic             ovf_o
);
    logic [CTR_W:0] next_full;

    assign next_full = {1'b0, cnt_o} + {{(CTR_W + 1 - SUM_W){1'b0}}, inc_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
            ovf_o <= 1'b0;
        end else begin
            if (cnt_wr_i) cnt_o <= cnt_wdata_i;
            else          cnt_o <= next_full[CTR_W-1:0];
            if (!cnt_wr_i && next_full[CTR_W]) ovf_o <= 1'b1;
            else if (clr_ovf_i)                ovf_o <= 1'b0;
        end
    end

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr_i && inc_i == '0) |=> $stable(cnt_o));

    // R11
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> (cnt_o == $past(cnt_wdata_i)));

    // R10
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_ovf_i) |=> ovf_o);
endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
    import qec_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int NSUB   = 8,
    parameter int CTR_W  = 40,
    parameter int CTR_ID = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC*NSUB-1:0] sub_evt_i,
    input  logic [1:0]           priv_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_addr_i,
    input  logic [CTR_W-1:0]     wr_data_i,
    input  logic [1:0]           rd_addr_i,
    output logic [CTR_W-1:0]     rd_data_o,
    output logic                 irq_o
);
    cfg_t             cfg_q, cfg_new;
    logic             cfg_wr, cnt_wr, clr_ovf, legal, ovf;
    logic [SUM_W-1:0] sum, inc;
    logic [CTR_W-1:0] cnt;

    assign cfg_new = cfg_t'(wr_data_i[CFG_W-1:0]);
    assign cfg_wr  = wr_en_i && (wr_addr_i == A_CFG);
    assign cnt_wr  = wr_en_i && (wr_addr_i == A_CNT);
    assign clr_ovf = wr_en_i && (wr_addr_i == A_STAT) && wr_data_i[0];

    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_new;
    end

    qec_event_sel #(.NSRC(NSRC), .NSUB(NSUB), .CTR_ID(CTR_ID)) u_sel (
        .sub_evt_i (sub_evt_i),
        .code_i    (cfg_q.code),
        .umask_i   (cfg_q.umask),
        .sum_o     (sum),
        .legal_o   (legal)
    );

    qec_qualifier u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .sum_i        (sum),
        .legal_i      (legal),
        .priv_i       (priv_i),
        .thr_i        (cfg_q.thr),
        .inv_i        (cfg_q.inv),
        .edge_i       (cfg_q.edge_en),
        .usr_i        (cfg_q.usr_en),
        .os_i         (cfg_q.os_en),
        .en_i         (cfg_q.en),
        .cfg_wr_i     (cfg_wr),
        .cfg_new_en_i (cfg_new.en),
        .inc_o        (inc)
    );

    qec_counter #(.CTR_W(CTR_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_i       (inc),
        .cnt_wr_i    (cnt_wr),
        .cnt_wdata_i (wr_data_i),
        .clr_ovf_i   (clr_ovf),
        .cnt_o       (cnt),
        .ovf_o       (ovf)
    );

    always_comb begin
        case (rd_addr_i)
            A_CFG:   rd_data_o = CTR_W'(cfg_q);
            A_CNT:   rd_data_o = cnt;
            A_STAT:  rd_data_o = CTR_W'(ovf);
            default: rd_data_o = '0;
        endcase
    end

    assign irq_o = ovf && cfg_q.int_en;

    // R8
    illegal_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |-> (inc == '0));
endmodule

// File: tb/qual_event_counter_test.sv
`timescale 1ns/1ps
module qual_event_counter_test;
    localparam int NSRC = 4;
    localparam int NSUB = 8;
    localparam int CW   = 40;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [31:0]     sub_evt;
    logic [1:0]      priv;
    logic            wr_en;
    logic [1:0]      wr_addr;
    logic [CW-1:0]   wr_data;
    logic [1:0]      rd_addr;
    logic [CW-1:0]   rd_data;
    logic            irq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    qual_event_counter uut (
        .clk(clk), .rst_n(rst_n), .sub_evt_i(sub_evt), .priv_i(priv),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    function automatic logic [CW-1:0] mkcfg(input logic [7:0] code, input logic [7:0] mask,
                                            input logic usr, input logic os, input logic edg,
                                            input logic ie, input logic en, input logic inv,
                                            input logic [2:0] thr);
        logic [CW-1:0] v;
        v = '0;
        v[7:0] = code; v[15:8] = mask; v[16] = usr; v[17] = os; v[18] = edg;
        v[19] = ie; v[20] = en; v[21] = inv; v[26:24] = thr;
        return v;
    endfunction

    function automatic logic [7:0] ones(input int k);
        logic [7:0] v;
        v = '0;
        for (int i = 0; i < 8; i++) if (i < k) v[i] = 1'b1;
        return v;
    endfunction

    task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [CW-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic set_src(input int s, input logic [7:0] bits, input logic [1:0] p);
        sub_evt = '0;
        sub_evt[s*8 +: 8] = bits;
        priv = p;
    endtask

    task automatic burst(input int s, input logic [7:0] bits, input logic [1:0] p, input int n);
        set_src(s, bits, p);
        repeat (n) @(negedge clk);
        sub_evt = '0;
    endtask

    task automatic setup(input logic [CW-1:0] c);
        wr(2'd0, c);
        wr(2'd1, '0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog R1..: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] v;
        rst_n = 1'b0; sub_evt = '0; priv = 2'd0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(2'd0, v); check("R1 cfg", v, 0);
        rd(2'd1, v); check("R1 cnt", v, 0);
        rd(2'd2, v); check("R1 stat", v, 0);
        check("R1 irq", {39'd0, irq}, 0);

        // R12 configuration readback
        wr(2'd0, mkcfg(8'h23, 8'hA5, 1, 0, 1, 0, 0, 1, 3'd5));
        rd(2'd0, v); check("R12 cfg readback", v, 40'h0525_A523);

        // R2 R3 R4 sweep over threshold, invert and per-cycle count
        for (int t = 0; t < 8; t++) begin
            for (int iv = 0; iv < 2; iv++) begin
                for (int k = 0; k < 8; k++) begin
                    int exp;
                    setup(mkcfg(8'h00, 8'hFF, 0, 0, 0, 0, 1, iv[0], 3'(t)));
                    burst(0, ones(k), 2'd1, 3);
                    rd(2'd1, v);
                    if (t == 0) exp = 3 * k;
                    else exp = (((k >= t) ? 1 : 0) ^ iv) * 3;
                    check(t == 0 ? "R2 sum" : (iv == 1 ? "R4 invert" : "R3 threshold"), v, CW'(exp));
                end
            end
        end

        // R2 saturation at 7 with all eight sub-events
        setup(mkcfg(8'h00, 8'hFF, 0, 0, 0, 0, 1, 0, 3'd0));
        burst(0, 8'hFF, 2'd0, 2);
        rd(2'd1, v); check("R2 saturate", v, 14);

        // R6 privilege filter
        for (int u = 0; u < 2; u++) begin
            for (int o = 0; o < 2; o++) begin
                for (int p = 0; p < 4; p++) begin
                    bit ok;
                    ok = (u == 0 && o == 0) || (p == 0 ? (o == 1) : (u == 1));
                    setup(mkcfg(8'h00, 8'hFF, u[0], o[0], 0, 0, 1, 0, 3'd0));
                    burst(0, ones(2), 2'(p), 2);
                    rd(2'd1, v); check("R6 privilege", v, ok ? 4 : 0);
                end
            end
        end

        // R7 source and mask selection
        setup(mkcfg(8'h02, 8'hFF, 0, 0, 0, 0, 1, 0, 3'd0));
        @(negedge clk);
        sub_evt = '0; sub_evt[15:8] = 8'hFF; sub_evt[31:24] = 8'hFF;
        repeat (3) @(negedge clk);
        sub_evt = '0;
        rd(2'd1, v); check("R7 other sources", v, 0);
        setup(mkcfg(8'h02, 8'hFF, 0, 0, 0, 0, 1, 0, 3'd0));
        burst(2, ones(4), 2'd0, 3);
        rd(2'd1, v); check("R7 source 2", v, 12);
        setup(mkcfg(8'h00, 8'h0C, 0, 0, 0, 0, 1, 0, 3'd0));
        burst(0, 8'hFF, 2'd0, 3);
        rd(2'd1, v); check("R7 mask 0C", v, 6);
        setup(mkcfg(8'h01, 8'h05, 0, 0, 0, 0, 1, 0, 3'd0));
        burst(1, 8'h0E, 2'd0, 3);
        rd(2'd1, v); check("R7 mask 05", v, 3);
        setup(mkcfg(8'h05, 8'hFF, 0, 0, 0, 0, 1, 0, 3'd0));
        @(negedge clk);
        sub_evt = '1;
        repeat (3) @(negedge clk);
        sub_evt = '0;
        rd(2'd1, v); check("R7 nibble 5 selects none", v, 0);

        // R8 restricted codes on counter index 0
        setup(mkcfg(8'h10, 8'hFF, 0, 0, 0, 0, 1, 0, 3'd0));
        burst(0, ones(2), 2'd0, 3);
        rd(2'd1, v); check("R8 even legal", v, 6);
        setup(mkcfg(8'h11, 8'hFF, 0, 0, 0, 0, 1, 0, 3'd0));
        burst(1, ones(2), 2'd0, 3);
        rd(2'd1, v); check("R8 odd blocked", v, 0);
        setup(mkcfg(8'h11, 8'hFF, 0, 0, 0, 0, 1, 1, 3'd3));
        burst(1, ones(1), 2'd0, 3);
        rd(2'd1, v); check("R8 odd blocked invert", v, 0);

        // R9 disabled
        setup(mkcfg(8'h00, 8'hFF, 0, 0, 0, 0, 0, 0, 3'd0));
        burst(0, ones(5), 2'd0, 4);
        rd(2'd1, v); check("R9 disabled", v, 0);

        // R5 edge counting
        setup(mkcfg(8'h00, 8'hFF, 0, 0, 1, 0, 1, 0, 3'd2));
        set_src(0, ones(3), 2'd0); repeat (4) @(negedge clk);
        set_src(0, ones(0), 2'd0); repeat (2) @(negedge clk);
        set_src(0, ones(3), 2'd0); repeat (1) @(negedge clk);
        set_src(0, ones(1), 2'd0); repeat (2) @(negedge clk);
        set_src(0, ones(3), 2'd0); repeat (2) @(negedge clk);
        sub_evt = '0;
        rd(2'd1, v); check("R5 edges", v, 3);
        setup(mkcfg(8'h00, 8'hFF, 0, 0, 1, 0, 1, 0, 3'd0));
        burst(0, ones(6), 2'd0, 5);
        rd(2'd1, v); check("R5 edge thr0", v, 1);
        // condition already true across the configuration write
        wr(2'd0, mkcfg(8'h00, 8'hFF, 0, 0, 0, 0, 0, 0, 3'd0));
        wr(2'd1, '0);
        set_src(0, ones(3), 2'd0);
        wr(2'd0, mkcfg(8'h00, 8'hFF, 0, 0, 1, 0, 1, 0, 3'd2));
        repeat (3) @(negedge clk);
        sub_evt = '0;
        rd(2'd1, v); check("R5 first cycle after write", v, 1);

        // R10 overflow and interrupt
        wr(2'd0, mkcfg(8'h00, 8'hFF, 0, 0, 0, 1, 1, 0, 3'd0));
        wr(2'd1, 40'hFF_FFFF_FFFE);
        burst(0, ones(3), 2'd0, 1);
        rd(2'd1, v); check("R10 wrap value", v, 1);
        rd(2'd2, v); check("R10 flag set", v, 1);
        check("R10 irq", {39'd0, irq}, 1);
        wr(2'd2, 40'd0);
        rd(2'd2, v); check("R10 write 0 keeps flag", v, 1);
        wr(2'd2, 40'd1);
        rd(2'd2, v); check("R10 flag cleared", v, 0);
        check("R10 irq cleared", {39'd0, irq}, 0);
        wr(2'd0, mkcfg(8'h00, 8'hFF, 0, 0, 0, 0, 1, 0, 3'd0));
        wr(2'd1, 40'hFF_FFFF_FFFF);
        burst(0, ones(1), 2'd0, 1);
        rd(2'd2, v); check("R10 flag without irq enable", v, 1);
        check("R10 irq masked", {39'd0, irq}, 0);
        wr(2'd2, 40'd1);

        // R11 counter write beats increment
        setup(mkcfg(8'h00, 8'hFF, 0, 0, 0, 0, 1, 0, 3'd0));
        @(negedge clk);
        set_src(0, ones(5), 2'd0);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 40'd100;
        @(negedge clk);
        wr_en = 1'b0; sub_evt = '0;
        rd(2'd1, v); check("R11 write priority", v, 100);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 40'hFF_FFFF_FFFF;
        set_src(0, ones(5), 2'd0);
        @(negedge clk);
        wr_en = 1'b0; sub_evt = '0;
        rd(2'd1, v); check("R11 write at all-ones", v, 40'hFF_FFFF_FFFF);
        rd(2'd2, v); check("R11 no overflow from dropped increment", v, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule